// File: doc/BRIEF.md
# Dual-Lane Rounding Packed Subtract Unit

This block finishes a halfword multiply-subtract operation. It receives two signed 32-bit products packed into one 64-bit word and two signed 32-bit minuend words. For each lane it subtracts the product from the minuend and adds a rounding term of 0x8000. The arithmetic is carried out in 34-bit signed precision. Each lane result is checked against the signed 32-bit range and, when saturation is selected, clamped to that range. The upper halfword of each lane result is then placed in a single 32-bit output word.

The minuends can also come from one 32-bit accumulator that holds two halfwords. In that form, bits 15:0 of the accumulator are moved up to become the upper half of the low minuend, and bits 31:16 stay in place to form the high minuend. Every accepted operation produces an overflow flag and an advance-overflow flag. Sticky copies of both flags build up across operations until a reset or a clear pulse removes them.

A small two-state controller handles timing. In IDLE no result is being presented. In RESULT the registered result of the operation accepted on the previous edge is presented. The transition IDLE→RESULT and the self-loop RESULT→RESULT are both taken when `op_valid` is high. The transition RESULT→IDLE and the self-loop IDLE→IDLE are both taken when `op_valid` is low.

Top module: `rsub_pack_unit`

## Requirements
- R1: For lane 0 (product bits 31:0, low minuend) and lane 1 (product bits 63:32, high minuend), the lane result is minuend − product + 0x8000, computed in signed arithmetic with no loss of range.
- R2: Output bits 31:16 hold lane 1 result bits 31:16, and output bits 15:0 hold lane 0 result bits 31:16.
- R3: A lane overflows when its result is greater than 2^31−1 or less than −2^31. `ovf` is the OR of the two lane overflows.
- R4: With `sat_en`=1, an overflowing lane is clamped to 0x7FFFFFFF when its result is too large and to 0x80000000 when it is too small, before packing.
- R5: With `sat_en`=0, overflow is still flagged, and the unclamped result truncated to 32 bits is packed.
- R6: `adv_ovf` is the OR over both lanes of bit 31 XOR bit 30 of the unclamped result truncated to 32 bits.
- R7: `ovf_sticky` and `adv_sticky` OR in the flags of every accepted operation. They fall only on reset or a clear.
- R8: A high `sticky_clr` clears both sticky bits on the next edge and leaves `result`, `ovf`, `adv_ovf` and `out_valid` unchanged. If an operation is accepted on the same edge, the sticky bits take that operation's flags.
- R9: With `pack_mode`=1, the low minuend is `acc` shifted left by 16 and the high minuend is `acc` with bits 15:0 cleared. `min_lo` and `min_hi` are then ignored.
- R10: An operation sampled with `op_valid` on one edge is presented with `out_valid`=1 after that edge. `out_valid` is 0 after an edge without `op_valid`, and `result`, `ovf` and `adv_ovf` then keep their values.
- R11: Synchronous reset sets `out_valid`, `result`, `ovf`, `adv_ovf` and both sticky bits to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operands valid; the operation is sampled on this edge |
| sat_en | input | 1 | 1 selects the saturating variant |
| pack_mode | input | 1 | 1 takes the minuends from `acc` |
| prod | input | 64 | Two signed products: lane 1 in bits 63:32, lane 0 in bits 31:0 |
| min_lo | input | 32 | Lane 0 minuend |
| min_hi | input | 32 | Lane 1 minuend |
| acc | input | 32 | Packed halfword accumulator |
| sticky_clr | input | 1 | Clears both sticky flags |
| out_valid | output | 1 | Result presented (RESULT state) |
| result | output | 32 | Packed rounded halfwords |
| ovf | output | 1 | Overflow flag of the last operation |
| adv_ovf | output | 1 | Advance-overflow flag of the last operation |
| ovf_sticky | output | 1 | Accumulated overflow |
| adv_sticky | output | 1 | Accumulated advance overflow |

## Verification
A fault in the lane arithmetic or the clamp shows up as a wrong packed halfword or a wrong flag. It appears in the very cycle after the operation is sampled, because nothing is pipelined beyond the one output register. A bad sticky bit is quieter: it may show only after a later clean operation, when the sticky bit should still be set while `ovf` has dropped, or after a lone clear pulse. The bench therefore follows each overflow with a clean operation and a clear pulse, and checks that the held result survives the clear.

// File: rtl/rps_pkg.sv
package rps_pkg;

    // Controller states: IDLE presents nothing, RESULT presents a fresh result.
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } rps_state_e;

    localparam int unsigned RPS_LANES = 2;

endpackage

// File: rtl/rps_minuend_sel.sv
module rps_minuend_sel #(
    parameter int unsigned W = 32
) (
    input  logic         pack_mode,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] min_lo_in,
    input  logic [W-1:0] min_hi_in,
    output logic [W-1:0] min_lo,
    output logic [W-1:0] min_hi
);
    localparam int unsigned HW = W / 2;

    always_comb begin
        if (pack_mode) begin
            min_lo = {acc[HW-1:0], {HW{1'b0}}};
            min_hi = {acc[W-1:HW], {HW{1'b0}}};
        end else begin
            min_lo = min_lo_in;
            min_hi = min_hi_in;
        end
    end

endmodule

// File: rtl/rps_lane.sv
module rps_lane #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]   minuend,
    input  logic [W-1:0]   product,
    input  logic           sat_en,
    output logic [W/2-1:0] half,
    output logic           lane_ovf,
    output logic           lane_adv
);
    localparam int unsigned HW = W / 2;
    localparam int unsigned XW = W + 2;
    localparam logic [XW-1:0] RND   = XW'(1) << (HW - 1);
    localparam logic [W-1:0]  POS_B = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0]  NEG_B = {1'b1, {(W-1){1'b0}}};

    logic [XW-1:0] m_x;
    logic [XW-1:0] p_x;
    logic [XW-1:0] sum;
    logic [2:0]    top;
    logic [W-1:0]  clamped;

    always_comb begin
        m_x      = {{2{minuend[W-1]}}, minuend};
        p_x      = {{2{product[W-1]}}, product};
        sum      = m_x - p_x + RND;
        top      = sum[XW-1:W-1];
        // In range only if the top three bits all agree.
        lane_ovf = !((&top) || (~|top));
        lane_adv = sum[W-1] ^ sum[W-2];
        if (sat_en && lane_ovf) begin
            clamped = sum[XW-1] ? NEG_B : POS_B;
        end else begin
            clamped = sum[W-1:0];
        end
        half = clamped[W-1:HW];
    end

endmodule

// File: rtl/rps_ctrl.sv
module rps_ctrl #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  logic         sticky_clr,
    input  logic [W-1:0] new_result,
    input  logic         new_ovf,
    input  logic         new_adv,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         ovf,
    output logic         adv_ovf,
    output logic         ovf_sticky,
    output logic         adv_sticky
);
    import rps_pkg::*;

    rps_state_e state_q;
    rps_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = op_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = op_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            result     <= '0;
            ovf        <= 1'b0;
            adv_ovf    <= 1'b0;
            ovf_sticky <= 1'b0;
            adv_sticky <= 1'b0;
        end else begin
            if (op_valid) begin
                result  <= new_result;
                ovf     <= new_ovf;
                adv_ovf <= new_adv;
            end
            ovf_sticky <= (ovf_sticky & ~sticky_clr) | (op_valid & new_ovf);
            adv_sticky <= (adv_sticky & ~sticky_clr) | (op_valid & new_adv);
        end
    end

    assign out_valid = (state_q == ST_RESULT);

endmodule

// File: rtl/rsub_pack_unit.sv
module rsub_pack_unit #(
    parameter int unsigned W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           op_valid,
    input  logic           sat_en,
    input  logic           pack_mode,
    input  logic [2*W-1:0] prod,
    input  logic [W-1:0]   min_lo,
    input  logic [W-1:0]   min_hi,
    input  logic [W-1:0]   acc,
    input  logic           sticky_clr,
    output logic           out_valid,
    output logic [W-1:0]   result,
    output logic           ovf,
    output logic           adv_ovf,
    output logic           ovf_sticky,
    output logic           adv_sticky
);
    import rps_pkg::*;

    localparam int unsigned HW = W / 2;

    logic [W-1:0]         sel_lo;
    logic [W-1:0]         sel_hi;
    logic [W-1:0]         mins  [RPS_LANES];
    logic [HW-1:0]        halves[RPS_LANES];
    logic [RPS_LANES-1:0] l_ovf;
    logic [RPS_LANES-1:0] l_adv;
    logic [W-1:0]         packed_res;

    rps_minuend_sel #(.W(W)) u_sel (
        .pack_mode (pack_mode),
        .acc       (acc),
        .min_lo_in (min_lo),
        .min_hi_in (min_hi),
        .min_lo    (sel_lo),
        .min_hi    (sel_hi)
    );

    assign mins[0] = sel_lo;
    assign mins[1] = sel_hi;

    for (genvar g = 0; g < RPS_LANES; g++) begin : g_lane
        rps_lane #(.W(W)) u_lane (
            .minuend  (mins[g]),
            .product  (prod[g*W +: W]),
            .sat_en   (sat_en),
            .half     (halves[g]),
            .lane_ovf (l_ovf[g]),
            .lane_adv (l_adv[g])
        );
    end

    assign packed_res = {halves[1], halves[0]};

    rps_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (op_valid),
        .sticky_clr (sticky_clr),
        .new_result (packed_res),
        .new_ovf    (|l_ovf),
        .new_adv    (|l_adv),
        .out_valid  (out_valid),
        .result     (result),
        .ovf        (ovf),
        .adv_ovf    (adv_ovf),
        .ovf_sticky (ovf_sticky),
        .adv_sticky (adv_sticky)
    );

endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         op_valid,
    input logic         sticky_clr,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         ovf,
    input logic         adv_ovf,
    input logic         ovf_sticky,
    input logic         adv_sticky
);
    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> out_valid);
    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !out_valid);
    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(result) && $stable(ovf) && $stable(adv_ovf)));
    // R7
    ovf_sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_sticky && !sticky_clr) |=> ovf_sticky);
    // R7
    adv_sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_sticky && !sticky_clr) |=> adv_sticky);
    // R7
    ovf_into_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ovf) |-> ovf_sticky);
    // R7
    adv_into_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && adv_ovf) |-> adv_sticky);
    // R8
    clear_alone_chk: assert property (@(posedge clk) disable iff (rst)
        (sticky_clr && !op_valid) |=> (!ovf_sticky && !adv_sticky));
endmodule

bind rsub_pack_unit rps_checker #(.W(W)) u_rps_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .sticky_clr (sticky_clr),
    .out_valid  (out_valid),
    .result     (result),
    .ovf        (ovf),
    .adv_ovf    (adv_ovf),
    .ovf_sticky (ovf_sticky),
    .adv_sticky (adv_sticky)
);

// File: tb/rsub_pack_unit_tb.sv
`timescale 1ns/1ps
module rsub_pack_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, sat_en, pack_mode, sticky_clr;
    logic [63:0] prod;
    logic [31:0] min_lo, min_hi, acc;
    logic        out_valid, ovf, adv_ovf, ovf_sticky, adv_sticky;
    logic [31:0] result;

    int checks = 0;
    int failures = 0;
    logic exp_so = 1'b0;
    logic exp_sa = 1'b0;

    always #10 clk = ~clk;

    rsub_pack_unit u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .sat_en(sat_en),
        .pack_mode(pack_mode), .prod(prod), .min_lo(min_lo), .min_hi(min_hi),
        .acc(acc), .sticky_clr(sticky_clr), .out_valid(out_valid),
        .result(result), .ovf(ovf), .adv_ovf(adv_ovf),
        .ovf_sticky(ovf_sticky), .adv_sticky(adv_sticky)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [63:0] p, input logic [31:0] lo,
                                  input logic [31:0] hi, input logic sat,
                                  output logic [31:0] r, output logic o,
                                  output logic a);
        o = 1'b0;
        a = 1'b0;
        r = '0;
        for (int i = 0; i < 2; i++) begin
            longint s;
            logic [31:0] t;
            logic        lo_ovf;
            s = longint'($signed(i == 0 ? lo : hi)) -
                longint'($signed(p[i*32 +: 32])) + 64'sd32768;
            t = s[31:0];
            lo_ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            o = o | lo_ovf;
            a = a | (t[31] ^ t[30]);
            if (sat && lo_ovf) t = (s < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
            r[i*16 +: 16] = t[31:16];
        end
    endfunction

    // Issue one op, then check outputs one cycle later.
    task automatic run_op(input string req, input logic [63:0] p,
                          input logic [31:0] lo, input logic [31:0] hi,
                          input logic [31:0] a_in, input logic pk,
                          input logic sat);
        logic [31:0] er, ulo, uhi;
        logic        eo, ea;
        @(negedge clk);
        prod = p; min_lo = lo; min_hi = hi; acc = a_in;
        pack_mode = pk; sat_en = sat; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        ulo = pk ? {a_in[15:0], 16'h0} : lo;
        uhi = pk ? {a_in[31:16], 16'h0} : hi;
        model(p, ulo, uhi, sat, er, eo, ea);
        exp_so = exp_so | eo;
        exp_sa = exp_sa | ea;
        chk({req, " valid"}, {31'b0, out_valid}, 32'd1);
        chk({req, " result"}, result, er);
        chk({req, " ovf"}, {31'b0, ovf}, {31'b0, eo});
        chk({req, " adv"}, {31'b0, adv_ovf}, {31'b0, ea});
        chk({req, " ovf_sticky R7"}, {31'b0, ovf_sticky}, {31'b0, exp_so});
        chk({req, " adv_sticky R7"}, {31'b0, adv_sticky}, {31'b0, exp_sa});
    endtask

    task automatic t_reset();
        // R11
        chk("R11 valid", {31'b0, out_valid}, 32'd0);
        chk("R11 result", result, 32'd0);
        chk("R11 flags", {28'b0, ovf, adv_ovf, ovf_sticky, adv_sticky}, 32'd0);
    endtask

    task automatic t_basic();
        // R1 R2: lane0 0x000F8000, lane1 0x001E8000
        run_op("R1 R2 basic", {32'h0002_0000, 32'h0001_0000},
               32'h0010_0000, 32'h0020_0000, 32'h0, 1'b0, 1'b0);
        chk("R2 literal", result, 32'h001E_000F);
        // R1 rounding carry: 0x00018000 + 0x8000 -> 0x0002
        run_op("R1 round", 64'h0, 32'h0001_8000, 32'h0000_7FFF,
               32'h0, 1'b0, 1'b0);
        chk("R1 round literal", result, 32'h0000_0002);
    endtask

    task automatic t_overflow();
        // R3 R4 positive clamp on lane 0
        run_op("R3 R4 pos sat", {32'h0, 32'hFFFF_FFFF},
               32'h7FFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b1);
        chk("R4 pos literal", result, 32'h0000_7FFF);
        // R5 same op, non-saturating
        run_op("R5 pos wrap", {32'h0, 32'hFFFF_FFFF},
               32'h7FFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b0);
        chk("R5 wrap literal", result, 32'h0000_8000);
        // R4 negative clamp on lane 1
        run_op("R3 R4 neg sat", {32'h7FFF_FFFF, 32'h0},
               32'h0, 32'h8000_0000, 32'h0, 1'b0, 1'b1);
        chk("R4 neg literal", result, 32'h8000_0000);
        run_op("R5 neg wrap", {32'h7FFF_FFFF, 32'h0},
               32'h0, 32'h8000_0000, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_adv();
        // R6 adv without ovf
        run_op("R6 adv", 64'h0, 32'h4000_0000, 32'h0, 32'h0, 1'b0, 1'b1);
        chk("R6 adv no ovf", {30'b0, ovf, adv_ovf}, 32'd1);
    endtask

    task automatic t_sticky_clear();
        logic [31:0] held;
        run_op("R7 clean", 64'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
        chk("R7 sticky kept", {30'b0, ovf_sticky, adv_sticky}, 32'd3);
        held = result;
        @(negedge clk);
        sticky_clr = 1'b1;
        @(negedge clk);
        sticky_clr = 1'b0;
        exp_so = 1'b0;
        exp_sa = 1'b0;
        chk("R8 cleared", {30'b0, ovf_sticky, adv_sticky}, 32'd0);
        chk("R8 result held", result, held);
        chk("R10 idle valid", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_packed();
        // R9: acc 0x12345678 -> lo 0x56780000, hi 0x12340000
        run_op("R9 packed", 64'h0, 32'hDEAD_BEEF, 32'hCAFE_F00D,
               32'h1234_5678, 1'b1, 1'b0);
        chk("R9 literal", result, 32'h1234_5678);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; sat_en = 1'b0; pack_mode = 1'b0;
        sticky_clr = 1'b0; prod = '0; min_lo = '0; min_hi = '0; acc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_overflow();
        t_adv();
        t_sticky_clear();
        t_packed();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule